// File: doc/BRIEF.md
# Cache-as-RAM address window mapper

This block lets a slice of an operand-cache data array serve as plain on-chip RAM. Any access whose physical address falls between 0x7C000000 and 0x7FFFFFFF, while the RAM mode is enabled, is steered to one of two 4 KB pages. Each page is a fixed run of 128 lines of the cache data array and not a separate memory. Two pins choose how addresses map onto the pages. An enable pin switches the window on. An index-mode pin chooses between a fine 8 KB interleave and a split at the window midpoint.

Each request is sampled in one cycle. The block decodes the window, picks a page and forms the line index and byte offset into the data array. It then performs a byte, word, long or 32-byte line access. Reads of bytes and words come back sign-extended. Writes touch only the addressed bytes. Every request gets exactly one registered response, and the response carries an error flag when the access is unmapped or misaligned.

Top module: `ocr_window_top`

## Requirements
- R1: Only addresses 0x7C000000 to 0x7FFFFFFF map to RAM. Any other address gives a response with rsp_err=1 and rsp_data=0, and a write to such an address changes no RAM byte.
- R2: With ram_en=0, every access, including one inside the window, gives rsp_err=1 and rsp_data=0, and writes are dropped. After ram_en returns to 1, the earlier contents are still readable.
- R3: With idx_mode=0, address bit 13 selects the page (0 gives page 0, 1 gives page 1), and bits 11:0 give the offset within the page. For example, 0x7C000000 and 0x7C001000 name the same byte, and 0x7C002000 names offset 0 of page 1.
- R4: With idx_mode=1, addresses below 0x7E000000 go to page 0 and addresses from 0x7E000000 upward go to page 1. The offset within the page is still bits 11:0.
- R5: The two pages are the same storage in both index modes. Page 0 is cache lines 128 to 255 and page 1 is lines 384 to 511, so a byte written in one mode can be read back through the other mode's mapping.
- R6: req_size encodes the access as 0 for byte, 1 for word, 2 for long and 3 for a 32-byte line. A byte read returns the byte sign-extended in rsp_data[31:0], a word read returns the word sign-extended, and a long read returns the long. Bits above 31 are zero for these three sizes.
- R7: Storage is little-endian. Byte k of a long holds bits 8k+7:8k. A byte, word or long write updates only the addressed bytes and takes its data from the low bits of req_wdata.
- R8: A line access (size 3) moves 32 bytes at the computed offset. Byte k of the block sits in bits 8k+7:8k of req_wdata on a write and of rsp_data on a read.
- R9: A word at an odd address, a long whose address bits 1:0 are not 0, or a line whose address bits 4:0 are not 0 is misaligned. Such an access gives rsp_err=1 and rsp_data=0 and writes nothing.
- R10: A request sampled at clock edge N is answered at edge N+2 with rsp_valid high for exactly one cycle. Writes answer with rsp_data=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Physical byte address |
| req_size | input | 2 | 0 byte, 1 word, 2 long, 3 line (32 bytes) |
| req_wdata | input | 256 | Write data; low bits for scalar sizes |
| ram_en | input | 1 | RAM mode enable |
| idx_mode | input | 1 | 0 = bit-13 interleave, 1 = midpoint split |
| rsp_valid | output | 1 | Response strobe, one cycle per request |
| rsp_err | output | 1 | Unmapped or misaligned access |
| rsp_data | output | 256 | Read data; scalar results in bits 31:0 |

## Verification
Address pairs that differ only in bit 12, bit 13 or bit 25 are used under both index modes. These show whether the page choice comes from the right bit and whether the offset keeps only the low 12 bits. One long word holds bytes of mixed sign, and it is read back as bytes and as words at each lane. This separates correct lane selection and sign extension from zero extension or swapped lanes, and a partial write into that word shows whether neighbouring bytes survive. Writes outside the window, with RAM disabled, and at misaligned addresses are each followed by a read of the location they could have hit. The read shows whether the access really was dropped and did not just get flagged.

// File: rtl/ocr_pkg.sv
package ocr_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_LINE = 2'd3
  } acc_size_e;
endpackage

// File: rtl/ocr_decode.sv
module ocr_decode
  import ocr_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] WIN_BASE  = 32'h7C00_0000,
  parameter int          WIN_LOG2  = 26,
  parameter int          PAGE_LOG2 = 12,
  parameter int          LINE_LOG2 = 5,
  parameter int          LINES     = 512,
  localparam int         LIDX_W    = $clog2(LINES)
) (
  input  logic [ADDR_W-1:0]    addr,
  input  acc_size_e            size,
  input  logic                 ram_en,
  input  logic                 idx_mode,
  output logic                 ok,
  output logic [LIDX_W-1:0]    line_idx,
  output logic [LINE_LOG2-1:0] byte_off
);
  localparam int ILV_BIT = PAGE_LOG2 + 1;
  localparam int MID_BIT = WIN_LOG2 - 1;
  localparam int QUARTER = LINES / 4;
  localparam logic [LIDX_W-1:0] BASE0 = LIDX_W'(QUARTER);
  localparam logic [LIDX_W-1:0] BASE1 = LIDX_W'(3 * QUARTER);

  logic in_win, page_sel, aligned;
  logic unused_addr_bits;

  assign unused_addr_bits = &{1'b0, addr};
  assign in_win   = (addr[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2]);
  assign page_sel = idx_mode ? addr[MID_BIT] : addr[ILV_BIT];
  assign byte_off = addr[LINE_LOG2-1:0];

  always_comb begin
    unique case (size)
      SZ_BYTE: aligned = 1'b1;
      SZ_WORD: aligned = (addr[0] == 1'b0);
      SZ_LONG: aligned = (addr[1:0] == 2'b00);
      default: aligned = (addr[LINE_LOG2-1:0] == '0);
    endcase
  end

  assign ok       = in_win && ram_en && aligned;
  assign line_idx = (page_sel ? BASE1 : BASE0)
                  + LIDX_W'(addr[PAGE_LOG2-1:LINE_LOG2]);
endmodule

// File: rtl/ocr_array.sv
module ocr_array #(
  parameter int  LINES      = 512,
  parameter int  LINE_BYTES = 32,
  localparam int LIDX_W     = $clog2(LINES),
  localparam int LINE_BITS  = LINE_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic [LIDX_W-1:0]     idx,
  input  logic [LINE_BYTES-1:0] be,
  input  logic [LINE_BITS-1:0]  wline,
  output logic [LINE_BITS-1:0]  rline
);
  logic [LINE_BITS-1:0] mem [LINES];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < LINE_BYTES; b++) begin
        if (be[b]) mem[idx][8*b +: 8] <= wline[8*b +: 8];
      end
    end
    rline <= mem[idx];
  end
endmodule

// File: rtl/ocr_format.sv
module ocr_format
  import ocr_pkg::*;
#(
  parameter int  LINE_LOG2 = 5,
  localparam int LINE_BITS = (1 << LINE_LOG2) * 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  acc_size_e            size,
  input  logic [LINE_LOG2-1:0] off,
  input  logic [LINE_BITS-1:0] line,
  output logic [LINE_BITS-1:0] data
);
  logic [7:0]  b_lane;
  logic [15:0] w_lane;
  logic [31:0] l_lane;

  assign b_lane = line[{off, 3'b000} +: 8];
  assign w_lane = line[{off[LINE_LOG2-1:1], 4'b0000} +: 16];
  assign l_lane = line[{off[LINE_LOG2-1:2], 5'b00000} +: 32];

  always_comb begin
    data = '0;
    if (en) begin
      unique case (size)
        SZ_BYTE: data[31:0] = {{24{b_lane[7]}}, b_lane};
        SZ_WORD: data[31:0] = {{16{w_lane[15]}}, w_lane};
        SZ_LONG: data[31:0] = l_lane;
        default: data       = line;
      endcase
    end
  end

  // R6: a byte result always carries its sign bit into bits 31:8
  a_r6_byte_sext: assert property (@(posedge clk) disable iff (rst)
    (en && size == SZ_BYTE) |-> (data[31:8] == {24{data[7]}}));
endmodule

// File: rtl/ocr_window_top.sv
module ocr_window_top
  import ocr_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter logic [31:0] WIN_BASE   = 32'h7C00_0000,
  parameter int          WIN_LOG2   = 26,
  parameter int          PAGE_LOG2  = 12,
  parameter int          LINE_LOG2  = 5,
  parameter int          LINES      = 512,
  localparam int         LINE_BYTES = 1 << LINE_LOG2,
  localparam int         LINE_BITS  = LINE_BYTES * 8,
  localparam int         LIDX_W     = $clog2(LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [1:0]           req_size,
  input  logic [LINE_BITS-1:0] req_wdata,
  input  logic                 ram_en,
  input  logic                 idx_mode,
  output logic                 rsp_valid,
  output logic                 rsp_err,
  output logic [LINE_BITS-1:0] rsp_data
);
  acc_size_e            size_in;
  logic                 dec_ok;
  logic [LIDX_W-1:0]    dec_line;
  logic [LINE_LOG2-1:0] dec_off;
  logic                 arr_we;
  logic [LINE_BYTES-1:0] be;
  logic [LINE_BITS-1:0] wline, rline, fmt_data;

  logic                 s_valid, s_write, s_ok;
  acc_size_e            s_size;
  logic [LINE_LOG2-1:0] s_off;

  assign size_in = acc_size_e'(req_size);

  ocr_decode #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2),
    .PAGE_LOG2(PAGE_LOG2), .LINE_LOG2(LINE_LOG2), .LINES(LINES)
  ) dec_i (
    .addr(req_addr), .size(size_in), .ram_en(ram_en), .idx_mode(idx_mode),
    .ok(dec_ok), .line_idx(dec_line), .byte_off(dec_off)
  );

  always_comb begin
    unique case (size_in)
      SZ_BYTE: begin
        be    = LINE_BYTES'(1) << dec_off;
        wline = {LINE_BYTES{req_wdata[7:0]}};
      end
      SZ_WORD: begin
        be    = LINE_BYTES'(3) << dec_off;
        wline = {(LINE_BYTES/2){req_wdata[15:0]}};
      end
      SZ_LONG: begin
        be    = LINE_BYTES'(15) << dec_off;
        wline = {(LINE_BYTES/4){req_wdata[31:0]}};
      end
      default: begin
        be    = '1;
        wline = req_wdata;
      end
    endcase
  end

  assign arr_we = req_valid && req_write && dec_ok;

  ocr_array #(.LINES(LINES), .LINE_BYTES(LINE_BYTES)) arr_i (
    .clk(clk), .we(arr_we), .idx(dec_line), .be(be), .wline(wline), .rline(rline)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s_valid <= 1'b0;
      s_write <= 1'b0;
      s_ok    <= 1'b0;
      s_size  <= SZ_BYTE;
      s_off   <= '0;
    end else begin
      s_valid <= req_valid;
      s_write <= req_write;
      s_ok    <= dec_ok;
      s_size  <= size_in;
      s_off   <= dec_off;
    end
  end

  ocr_format #(.LINE_LOG2(LINE_LOG2)) fmt_i (
    .clk(clk), .rst(rst), .en(s_valid && s_ok && !s_write),
    .size(s_size), .off(s_off), .line(rline), .data(fmt_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= s_valid;
      rsp_err   <= s_valid && !s_ok;
      rsp_data  <= s_valid ? fmt_data : '0;
    end
  end

  // R10: a response only ever follows a request two edges earlier
  a_r10_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid, 2));

  // R1: a flagged response never carries data
  a_r1_err_reads_zero: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_data == '0));

  // R2: a request made with RAM disabled is answered as an error
  a_r2_disabled_err: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !$past(ram_en, 2)) |-> rsp_err);

  // R5: a mapped access lands in the upper half of a half of the array
  a_r5_page_slice: assert property (@(posedge clk) disable iff (rst)
    (req_valid && dec_ok) |-> dec_line[LIDX_W-2]);
endmodule

// File: tb/ocr_window_top_tb_top.sv
module ocr_window_top_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_write = 1'b0;
  logic [31:0]  req_addr = '0;
  logic [1:0]   req_size = '0;
  logic [255:0] req_wdata = '0;
  logic         ram_en = 1'b1;
  logic         idx_mode = 1'b0;
  logic         rsp_valid, rsp_err;
  logic [255:0] rsp_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [255:0] exp_data_q[$];
  bit           exp_err_q[$];
  int           exp_cyc_q[$];
  string        exp_tag_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ocr_window_top dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .ram_en(ram_en), .idx_mode(idx_mode),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data)
  );

  function automatic logic [255:0] line_pat();
    logic [255:0] p;
    for (int k = 0; k < 32; k++) p[8*k +: 8] = 8'(k * 7 + 3);
    return p;
  endfunction

  function automatic logic [255:0] w32(input logic [31:0] v);
    return {224'd0, v};
  endfunction

  task automatic issue(input bit wr, input logic [31:0] a, input logic [1:0] sz,
                       input logic [255:0] wd, input logic [255:0] ed,
                       input bit ee, input string tag);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_size  = sz;
    req_wdata = wd;
    exp_data_q.push_back(ed);
    exp_err_q.push_back(ee);
    exp_cyc_q.push_back(cyc + 2);
    exp_tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [31:0] a, input logic [1:0] sz,
                    input logic [255:0] ed, input bit ee, input string tag);
    issue(1'b0, a, sz, '0, ed, ee, tag);
  endtask

  task automatic wr(input logic [31:0] a, input logic [1:0] sz,
                    input logic [255:0] wd, input bit ee, input string tag);
    issue(1'b1, a, sz, wd, '0, ee, tag);
  endtask

  // Monitor: scoreboard comparison
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      checks++;
      if (exp_data_q.size() == 0) begin
        errors++;
        $display("FAIL R10: unexpected response, actual valid=1 expected valid=0");
      end else begin
        logic [255:0] ed;
        bit ee;
        int ec;
        string t;
        ed = exp_data_q.pop_front();
        ee = exp_err_q.pop_front();
        ec = exp_cyc_q.pop_front();
        t  = exp_tag_q.pop_front();
        if (ec != cyc) begin
          errors++;
          $display("FAIL R10 (%s): response cycle actual=%0d expected=%0d", t, cyc, ec);
        end else if (rsp_err !== ee || rsp_data !== ed) begin
          errors++;
          $display("FAIL %s: actual err=%0b data=%h expected err=%0b data=%h",
                   t, rsp_err, rsp_data, ee, ed);
        end
      end
    end
  end

  initial begin
    logic [255:0] p;
    p = line_pat();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_err !== 1'b0 || rsp_data !== '0) begin
      errors++;
      $display("FAIL R10 reset: actual valid=%0b err=%0b expected 0 0", rsp_valid, rsp_err);
    end

    // R3: index mode 0, bit 13 interleave
    ram_en = 1'b1; idx_mode = 1'b0;
    wr(32'h7C00_0000, 2'd2, w32(32'h1122_3344), 1'b0, "R3 wr p0");
    rd(32'h7C00_0000, 2'd2, w32(32'h1122_3344), 1'b0, "R3 rd p0");
    rd(32'h7C00_1000, 2'd2, w32(32'h1122_3344), 1'b0, "R3 bit12 alias");
    wr(32'h7C00_2000, 2'd2, w32(32'hAABB_CCDD), 1'b0, "R3 wr p1");
    rd(32'h7C00_0000, 2'd2, w32(32'h1122_3344), 1'b0, "R3 p0 kept");
    rd(32'h7C00_3000, 2'd2, w32(32'hAABB_CCDD), 1'b0, "R3 p1 alias");
    rd(32'h7C00_4000, 2'd2, w32(32'h1122_3344), 1'b0, "R3 8KB repeat");
    rd(32'h7E00_2000, 2'd2, w32(32'hAABB_CCDD), 1'b0, "R3 bit25 ignored");
    idle(1);

    // R4 / R5: midpoint split, shared storage
    idx_mode = 1'b1;
    rd(32'h7E00_0000, 2'd2, w32(32'hAABB_CCDD), 1'b0, "R4 R5 upper half p1");
    rd(32'h7C00_2000, 2'd2, w32(32'h1122_3344), 1'b0, "R4 bit13 ignored");
    rd(32'h7DFF_F000, 2'd2, w32(32'h1122_3344), 1'b0, "R4 below mid p0");
    wr(32'h7FFF_F010, 2'd2, w32(32'h5566_7788), 1'b0, "R5 wr p1 mode1");
    idle(1);
    idx_mode = 1'b0;
    rd(32'h7C00_2010, 2'd2, w32(32'h5566_7788), 1'b0, "R5 rd p1 mode0");
    idle(1);

    // R6: lane selection and sign extension
    wr(32'h7C00_0004, 2'd2, w32(32'h807F_80FF), 1'b0, "R6 setup");
    wr(32'h7C00_0008, 2'd2, w32(32'h0000_1234), 1'b0, "R6 setup2");
    rd(32'h7C00_0004, 2'd0, w32(32'hFFFF_FFFF), 1'b0, "R6 byte0");
    rd(32'h7C00_0005, 2'd0, w32(32'hFFFF_FF80), 1'b0, "R6 byte1");
    rd(32'h7C00_0006, 2'd0, w32(32'h0000_007F), 1'b0, "R6 byte2");
    rd(32'h7C00_0004, 2'd1, w32(32'hFFFF_80FF), 1'b0, "R6 word lo");
    rd(32'h7C00_0006, 2'd1, w32(32'hFFFF_807F), 1'b0, "R6 word hi");
    rd(32'h7C00_0008, 2'd1, w32(32'h0000_1234), 1'b0, "R6 word pos");

    // R7: partial writes
    wr(32'h7C00_0005, 2'd0, w32(32'h0000_005A), 1'b0, "R7 byte wr");
    rd(32'h7C00_0004, 2'd2, w32(32'h807F_5AFF), 1'b0, "R7 byte merge");
    wr(32'h7C00_0006, 2'd1, w32(32'h0000_0102), 1'b0, "R7 word wr");
    rd(32'h7C00_0004, 2'd2, w32(32'h0102_5AFF), 1'b0, "R7 word merge");

    // R8: line access
    wr(32'h7C00_0020, 2'd3, p, 1'b0, "R8 line wr");
    rd(32'h7C00_0020, 2'd3, p, 1'b0, "R8 line rd");
    rd(32'h7C00_002C, 2'd2, w32(p[96 +: 32]), 1'b0, "R8 long in line");
    rd(32'h7C00_0004, 2'd2, w32(32'h0102_5AFF), 1'b0, "R8 neighbour line kept");

    // R1: outside the window
    rd(32'h8000_0000, 2'd2, '0, 1'b1, "R1 above");
    rd(32'h7BFF_FFFC, 2'd2, '0, 1'b1, "R1 below");
    wr(32'h3C00_0000, 2'd2, w32(32'hDEAD_BEEF), 1'b1, "R1 wr outside");
    rd(32'h7C00_0000, 2'd2, w32(32'h1122_3344), 1'b0, "R1 outside wr ignored");
    idle(1);

    // R2: disabled
    ram_en = 1'b0;
    rd(32'h7C00_0000, 2'd2, '0, 1'b1, "R2 rd disabled");
    wr(32'h7C00_0000, 2'd2, w32(32'h0000_DEAD), 1'b1, "R2 wr disabled");
    idle(1);
    ram_en = 1'b1;
    rd(32'h7C00_0000, 2'd2, w32(32'h1122_3344), 1'b0, "R2 contents kept");

    // R9: misalignment
    rd(32'h7C00_0001, 2'd1, '0, 1'b1, "R9 odd word");
    rd(32'h7C00_0002, 2'd2, '0, 1'b1, "R9 long off2");
    rd(32'h7C00_0030, 2'd3, '0, 1'b1, "R9 line off16");
    wr(32'h7C00_0006, 2'd2, w32(32'hFFFF_FFFF), 1'b1, "R9 misaligned wr");
    rd(32'h7C00_0004, 2'd2, w32(32'h0102_5AFF), 1'b0, "R9 misaligned wr ignored");
    idle(6);

    checks++;
    if (exp_data_q.size() != 0) begin
      errors++;
      $display("FAIL R10: missing responses actual=%0d pending expected=0", exp_data_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10: watchdog expired, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule